// File: doc/BRIEF.md
# Dual-Mode Reset Sequencer

This controller decides how a companion memory-and-logic device comes out of reset. It watches an active-low reset pin and sorts every qualified reset into one of two classes. A cold reset is the first reset after the supply-good flag comes up, or the first after that flag has dropped. A warm reset is any later one. Each class needs its own minimum number of low samples. A low pulse that falls short of the minimum for its class is taken as a glitch and does nothing.

Once a reset is recognised, the block holds the device in its reset condition. In that condition the MCU-side I/O is forced to input, the address, data and peripheral pins are tri-stated, and the flash controller is told to abort any program or erase and return to read. After the pin goes high again, the block waits a fixed recovery period before it raises the access-ready flag. The block also sends one-cycle clear strobes to each register class. Which strobes fire depends on the reset class. It gives the value to load into the mode register and blocks flash write starts while the low-voltage lockout flag is set. A power-down request from the running state tri-states only the data and peripheral pins.

The supply-good flag also serves as the block's own asynchronous initialiser. The reset pin is taken to be already synchronous to `clk`.

Top module: `rst_sequencer`

## Requirements
- R1: While `supply_ok` is low, `access_ready` is 0. `mcu_in_force`, `addr_hiz`, `data_hiz`, `periph_hiz`, `flash_abort` and `rst_cold` are all 1, and every clear strobe is 0.
- R2: After `supply_ok` rises, a reset is recognised only after `COLD_MIN` consecutive clock edges sample `rst_pin_n` low. A shorter pulse, even one of `WARM_MIN` samples or more, is ignored. Any drop of `supply_ok` makes the next reset cold again.
- R3: Once running, a reset is recognised after `WARM_MIN` consecutive low samples and is classed warm. A pulse with fewer low samples is ignored: `access_ready` stays 1, no tri-state or strobe output changes, and no strobe fires.
- R4: After a recognised reset, `access_ready` rises at the `RECOVERY_CYCLES`-th consecutive edge that samples `rst_pin_n` high. Any low sample restarts the count. The count is the same for both classes.
- R5: In the cycle after a reset is recognised, `mode_load` and `clr_misc` pulse high for one cycle. `clr_pwr_mgmt` and `clr_macrocell` pulse as well only when the reset is cold.
- R6: `mode_init` equals `MODE_DEFAULT` with the bits set in `MODE_ZERO_MASK` forced to 0. With the defaults (0xA5, mask 0x81, so bits 7 and 0) this gives 0x24.
- R7: Whenever `access_ready` is 0, `mcu_in_force`, `addr_hiz`, `data_hiz`, `periph_hiz` and `flash_abort` are all 1.
- R8: While running, `pdown_req`=1 sets `data_hiz` and `periph_hiz` to 1. `mcu_in_force` stays 0 and no strobe fires.
- R9: `flash_wr_go` follows `flash_wr_req` only while `access_ready` is 1 and `lv_lockout` is 0. Otherwise it is 0.
- R10: `pld_valid` stays 1 throughout a warm reset. During a cold reset it equals `cfg_done`.
- R11: `rst_cold` reports the class of the last recognised reset: 1 for cold, 0 for warm. It is 1 from supply-up until a warm reset is recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| supply_ok | input | 1 | Supply stable flag; low initialises the block asynchronously |
| rst_pin_n | input | 1 | Active-low reset pin, synchronous to clk |
| lv_lockout | input | 1 | Low-voltage lockout flag |
| pdown_req | input | 1 | Power-down mode request |
| cfg_done | input | 1 | Internal configuration load finished |
| flash_wr_req | input | 1 | Request to start a flash write cycle |
| access_ready | output | 1 | Memory access allowed |
| rst_cold | output | 1 | Class of the last recognised reset (1 = cold) |
| clr_pwr_mgmt | output | 1 | Clear strobe for the power-management registers |
| clr_macrocell | output | 1 | Forced clear strobe for macrocell flip-flops |
| mode_load | output | 1 | Load strobe for the mode register |
| mode_init | output | MODE_W | Value to load into the mode register |
| clr_misc | output | 1 | Clear strobe for all other registers |
| mcu_in_force | output | 1 | Force MCU-side I/O to input |
| addr_hiz | output | 1 | Tri-state the address output |
| data_hiz | output | 1 | Tri-state the data port |
| periph_hiz | output | 1 | Tri-state the peripheral I/O |
| flash_abort | output | 1 | Abort program/erase and return the flash controller to read |
| flash_wr_go | output | 1 | Gated flash write start |
| pld_valid | output | 1 | PLD outputs may be trusted |

## Verification
The pulse-width logic is driven with low pulses just below and exactly at each threshold, in both the cold and the warm context. This separates a glitch from a qualified reset, and it shows that the threshold tracks the class rather than being fixed. A warm-length pulse sent straight after a supply drop shows that the cold rule applies again. The strobe counts after cold and warm resets separate the two clearing rules. Recovery is timed edge by edge, including a case where a one-sample glitch restarts the count. Power-down and lockout are each toggled against a running device to confirm that they affect only their own outputs.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,  // supply up, no reset qualified yet
    PH_HOLD = 2'd1,  // reset condition, counting recovery while pin high
    PH_RUN  = 2'd2   // device operational
  } rst_phase_e;

  // Number of low samples needed to qualify a reset of the given class.
  function automatic int unsigned low_threshold(input logic cold,
                                                input int unsigned warm_min,
                                                input int unsigned cold_min);
    return cold ? cold_min : warm_min;
  endfunction

  // Mode register reset value: configured default with forced-zero bits.
  function automatic logic [7:0] mode_reset_value(input logic [7:0] dflt,
                                                  input logic [7:0] zero_mask);
    return dflt & ~zero_mask;
  endfunction

endpackage

// File: rtl/rst_pulse_qual.sv
module rst_pulse_qual
  import rst_seq_pkg::*;
#(
  parameter int unsigned WARM_MIN = 4,
  parameter int unsigned COLD_MIN = 16
) (
  input  logic clk,
  input  logic supply_ok,
  input  logic rst_pin_n,
  input  logic cold_pend,
  output logic recog
);
  localparam int unsigned LW = $clog2(COLD_MIN + 1);
  localparam logic [LW-1:0] SAT = LW'(COLD_MIN);

  logic [LW-1:0] low_cnt;
  logic [LW-1:0] thr_m1;

  always_comb thr_m1 = LW'(low_threshold(cold_pend, WARM_MIN, COLD_MIN) - 1);

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok)          low_cnt <= '0;
    else if (rst_pin_n)      low_cnt <= '0;
    else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
  end

  // Fires once, on the edge that takes the low run to the threshold.
  assign recog = !rst_pin_n && (low_cnt == thr_m1);

endmodule

// File: rtl/rst_phase_fsm.sv
module rst_phase_fsm
  import rst_seq_pkg::*;
#(
  parameter int unsigned RECOVERY_CYCLES = 8
) (
  input  logic       clk,
  input  logic       supply_ok,
  input  logic       rst_pin_n,
  input  logic       recog,
  output rst_phase_e phase,
  output logic       cold_pend,
  output logic       cold_cls
);
  localparam int unsigned RW = $clog2(RECOVERY_CYCLES + 1);
  localparam logic [RW-1:0] LAST = RW'(RECOVERY_CYCLES - 1);

  logic [RW-1:0] rec_cnt;

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      phase     <= PH_WAIT;
      rec_cnt   <= '0;
      cold_pend <= 1'b1;
      cold_cls  <= 1'b1;
    end else if (recog) begin
      phase     <= PH_HOLD;
      rec_cnt   <= '0;
      cold_pend <= 1'b0;
      cold_cls  <= cold_pend;
    end else if (phase == PH_HOLD) begin
      if (!rst_pin_n) begin
        rec_cnt <= '0;
      end else if (rec_cnt == LAST) begin
        phase   <= PH_RUN;
        rec_cnt <= '0;
      end else begin
        rec_cnt <= rec_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rst_io_ctl.sv
module rst_io_ctl
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       supply_ok,
  input  rst_phase_e phase,
  input  logic       recog,
  input  logic       cold_pend,
  input  logic       cold_cls,
  input  logic       pdown_req,
  input  logic       cfg_done,
  input  logic       lv_lockout,
  input  logic       flash_wr_req,
  output logic       clr_pwr_mgmt,
  output logic       clr_macrocell,
  output logic       mode_load,
  output logic       clr_misc,
  output logic       mcu_in_force,
  output logic       addr_hiz,
  output logic       data_hiz,
  output logic       periph_hiz,
  output logic       flash_abort,
  output logic       flash_wr_go,
  output logic       pld_valid
);
  logic in_rst;
  logic pdown_act;

  assign in_rst    = (phase != PH_RUN);
  assign pdown_act = pdown_req && !in_rst;

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      clr_pwr_mgmt  <= 1'b0;
      clr_macrocell <= 1'b0;
      mode_load     <= 1'b0;
      clr_misc      <= 1'b0;
    end else begin
      clr_pwr_mgmt  <= recog && cold_pend;
      clr_macrocell <= recog && cold_pend;
      mode_load     <= recog;
      clr_misc      <= recog;
    end
  end

  assign mcu_in_force = in_rst;
  assign addr_hiz     = in_rst;
  assign data_hiz     = in_rst || pdown_act;
  assign periph_hiz   = in_rst || pdown_act;
  assign flash_abort  = in_rst;
  assign flash_wr_go  = flash_wr_req && !lv_lockout && !in_rst;
  assign pld_valid    = cfg_done || !(in_rst && cold_cls);

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_seq_pkg::*;
#(
  parameter int unsigned WARM_MIN        = 4,
  parameter int unsigned COLD_MIN        = 16,
  parameter int unsigned RECOVERY_CYCLES = 8,
  parameter int unsigned MODE_W          = 8,
  parameter logic [MODE_W-1:0] MODE_DEFAULT   = 8'hA5,
  parameter logic [MODE_W-1:0] MODE_ZERO_MASK = 8'h81
) (
  input  logic              clk,
  input  logic              supply_ok,
  input  logic              rst_pin_n,
  input  logic              lv_lockout,
  input  logic              pdown_req,
  input  logic              cfg_done,
  input  logic              flash_wr_req,
  output logic              access_ready,
  output logic              rst_cold,
  output logic              clr_pwr_mgmt,
  output logic              clr_macrocell,
  output logic              mode_load,
  output logic [MODE_W-1:0] mode_init,
  output logic              clr_misc,
  output logic              mcu_in_force,
  output logic              addr_hiz,
  output logic              data_hiz,
  output logic              periph_hiz,
  output logic              flash_abort,
  output logic              flash_wr_go,
  output logic              pld_valid
);
  localparam logic [7:0] DEF8  = 8'(MODE_DEFAULT);
  localparam logic [7:0] MASK8 = 8'(MODE_ZERO_MASK);

  logic       rst_recog;
  logic       cold_pend;
  logic       cold_cls;
  rst_phase_e phase;

  rst_pulse_qual #(.WARM_MIN(WARM_MIN), .COLD_MIN(COLD_MIN)) u_qual (
    .clk(clk), .supply_ok(supply_ok), .rst_pin_n(rst_pin_n),
    .cold_pend(cold_pend), .recog(rst_recog)
  );

  rst_phase_fsm #(.RECOVERY_CYCLES(RECOVERY_CYCLES)) u_fsm (
    .clk(clk), .supply_ok(supply_ok), .rst_pin_n(rst_pin_n),
    .recog(rst_recog), .phase(phase), .cold_pend(cold_pend),
    .cold_cls(cold_cls)
  );

  rst_io_ctl u_io (
    .clk(clk), .supply_ok(supply_ok), .phase(phase), .recog(rst_recog),
    .cold_pend(cold_pend), .cold_cls(cold_cls), .pdown_req(pdown_req),
    .cfg_done(cfg_done), .lv_lockout(lv_lockout),
    .flash_wr_req(flash_wr_req), .clr_pwr_mgmt(clr_pwr_mgmt),
    .clr_macrocell(clr_macrocell), .mode_load(mode_load),
    .clr_misc(clr_misc), .mcu_in_force(mcu_in_force),
    .addr_hiz(addr_hiz), .data_hiz(data_hiz), .periph_hiz(periph_hiz),
    .flash_abort(flash_abort), .flash_wr_go(flash_wr_go),
    .pld_valid(pld_valid)
  );

  assign access_ready = (phase == PH_RUN);
  assign rst_cold     = cold_cls;
  assign mode_init    = MODE_W'(mode_reset_value(DEF8, MASK8));

endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk (
  input logic clk,
  input logic supply_ok,
  input logic rst_pin_n,
  input logic access_ready,
  input logic rst_cold,
  input logic clr_pwr_mgmt,
  input logic clr_macrocell,
  input logic clr_misc,
  input logic mcu_in_force,
  input logic addr_hiz,
  input logic data_hiz,
  input logic periph_hiz,
  input logic flash_abort,
  input logic pld_valid,
  input logic rst_recog
);
  AST_READY_AFTER_HIGH: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(access_ready) |-> $past(rst_pin_n)); // R4

  AST_RESET_PIN_STATE: assert property (@(posedge clk) disable iff (!supply_ok)
    !access_ready |-> (mcu_in_force && addr_hiz && data_hiz && periph_hiz && flash_abort)); // R7

  AST_COLD_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!supply_ok)
    (clr_pwr_mgmt || clr_macrocell) |-> rst_cold); // R5

  AST_STROBE_IN_RESET: assert property (@(posedge clk) disable iff (!supply_ok)
    clr_misc |-> !access_ready); // R5

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!supply_ok)
    clr_misc |=> !clr_misc); // R5

  AST_RECOG_DROPS_READY: assert property (@(posedge clk) disable iff (!supply_ok)
    rst_recog |=> !access_ready); // R7

  AST_WARM_PLD_VALID: assert property (@(posedge clk) disable iff (!supply_ok)
    !rst_cold |-> pld_valid); // R10
endmodule

bind rst_sequencer rst_sequencer_chk u_chk (
  .clk(clk), .supply_ok(supply_ok), .rst_pin_n(rst_pin_n),
  .access_ready(access_ready), .rst_cold(rst_cold),
  .clr_pwr_mgmt(clr_pwr_mgmt), .clr_macrocell(clr_macrocell),
  .clr_misc(clr_misc), .mcu_in_force(mcu_in_force), .addr_hiz(addr_hiz),
  .data_hiz(data_hiz), .periph_hiz(periph_hiz), .flash_abort(flash_abort),
  .pld_valid(pld_valid), .rst_recog(rst_recog)
);

// File: tb/rst_sequencer_bench.sv
module rst_sequencer_bench;
  localparam int WARM = 4;
  localparam int COLD = 16;
  localparam int REC  = 8;

  logic clk = 1'b0;
  logic supply_ok = 1'b0, rst_pin_n = 1'b1, lv_lockout = 1'b0;
  logic pdown_req = 1'b0, cfg_done = 1'b0, flash_wr_req = 1'b0;
  logic access_ready, rst_cold, clr_pwr_mgmt, clr_macrocell, mode_load, clr_misc;
  logic mcu_in_force, addr_hiz, data_hiz, periph_hiz, flash_abort, flash_wr_go, pld_valid;
  logic [7:0] mode_init;

  int checks = 0, failures = 0;
  int n_pm = 0, n_mc = 0, n_mode = 0, n_misc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rst_sequencer u_rst_sequencer (
    .clk(clk), .supply_ok(supply_ok), .rst_pin_n(rst_pin_n),
    .lv_lockout(lv_lockout), .pdown_req(pdown_req), .cfg_done(cfg_done),
    .flash_wr_req(flash_wr_req), .access_ready(access_ready),
    .rst_cold(rst_cold), .clr_pwr_mgmt(clr_pwr_mgmt),
    .clr_macrocell(clr_macrocell), .mode_load(mode_load),
    .mode_init(mode_init), .clr_misc(clr_misc),
    .mcu_in_force(mcu_in_force), .addr_hiz(addr_hiz), .data_hiz(data_hiz),
    .periph_hiz(periph_hiz), .flash_abort(flash_abort),
    .flash_wr_go(flash_wr_go), .pld_valid(pld_valid)
  );

  always @(posedge clk) begin
    if (clr_pwr_mgmt)  n_pm++;
    if (clr_macrocell) n_mc++;
    if (mode_load)     n_mode++;
    if (clr_misc)      n_misc++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // Low pulse of n samples, pin raised at the negedge after the n-th posedge.
  task automatic pulse(input int n);
    @(negedge clk); rst_pin_n = 1'b0;
    repeat (n) @(negedge clk);
    rst_pin_n = 1'b1;
  endtask

  task automatic edges_to_ready(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); n++;
      if (access_ready) break;
    end
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    eq("R1 ready", access_ready, 0);
    eq("R1 hiz", {addr_hiz, data_hiz, periph_hiz, mcu_in_force, flash_abort}, 5'b11111);
    eq("R1 cold", rst_cold, 1);
    eq("R1 strobes", {clr_pwr_mgmt, clr_macrocell, mode_load, clr_misc}, 0);
    eq("R6 mode_init", mode_init, 8'h24);
  endtask

  task automatic t_cold_short;
    int b;
    supply_ok = 1'b1;
    b = n_misc;
    pulse(COLD - 1);
    repeat (REC + 4) @(negedge clk);
    eq("R2 short cold ignored ready", access_ready, 0);
    eq("R2 short cold no strobe", n_misc - b, 0);
  endtask

  task automatic t_cold_full;
    int b_pm, b_mc, b_mode, b_misc, n;
    b_pm = n_pm; b_mc = n_mc; b_mode = n_mode; b_misc = n_misc;
    pulse(COLD);
    eq("R10 cold pld before cfg", pld_valid, 0);
    eq("R7 cold outputs", {addr_hiz, data_hiz, periph_hiz, mcu_in_force, flash_abort}, 5'b11111);
    cfg_done = 1'b1; #1;
    eq("R10 cold pld after cfg", pld_valid, 1);
    edges_to_ready(n);
    eq("R4 cold recovery edges", n, REC);
    eq("R5 cold pm strobe", n_pm - b_pm, 1);
    eq("R5 cold mc strobe", n_mc - b_mc, 1);
    eq("R5 cold mode strobe", n_mode - b_mode, 1);
    eq("R5 cold misc strobe", n_misc - b_misc, 1);
    eq("R11 cold class", rst_cold, 1);
    eq("R7 released", {addr_hiz, data_hiz, periph_hiz, mcu_in_force, flash_abort}, 0);
  endtask

  task automatic t_glitch;
    int b, bad;
    b = n_misc; bad = 0;
    @(negedge clk); rst_pin_n = 1'b0;
    for (int i = 0; i < WARM - 1; i++) begin
      @(negedge clk);
      if (!access_ready || addr_hiz || mcu_in_force || !pld_valid) bad++;
    end
    rst_pin_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!access_ready || addr_hiz) bad++;
    end
    eq("R3 glitch no output change", bad, 0);
    eq("R3 glitch no strobe", n_misc - b, 0);
  endtask

  task automatic t_warm;
    int b_pm, b_mc, b_mode, b_misc, n;
    b_pm = n_pm; b_mc = n_mc; b_mode = n_mode; b_misc = n_misc;
    cfg_done = 1'b0;
    pulse(WARM);
    eq("R3 warm recognised", access_ready, 0);
    eq("R11 warm class", rst_cold, 0);
    eq("R10 warm pld valid", pld_valid, 1);
    eq("R7 warm outputs", {addr_hiz, data_hiz, periph_hiz, mcu_in_force, flash_abort}, 5'b11111);
    repeat (3) @(negedge clk);
    pulse(1);
    edges_to_ready(n);
    eq("R4 restart after low sample", n, REC);
    eq("R5 warm pm none", n_pm - b_pm, 0);
    eq("R5 warm mc none", n_mc - b_mc, 0);
    eq("R5 warm mode", n_mode - b_mode, 1);
    eq("R5 warm misc", n_misc - b_misc, 1);
    cfg_done = 1'b1;
  endtask

  task automatic t_pdown;
    int b;
    b = n_misc;
    @(negedge clk); pdown_req = 1'b1;
    repeat (3) @(negedge clk);
    eq("R8 pdown data/periph", {data_hiz, periph_hiz}, 2'b11);
    eq("R8 pdown mcu unchanged", mcu_in_force, 0);
    eq("R8 pdown ready", access_ready, 1);
    eq("R8 pdown no strobe", n_misc - b, 0);
    pdown_req = 1'b0; #1;
    eq("R8 pdown exit", {data_hiz, periph_hiz}, 0);
  endtask

  task automatic t_lockout;
    @(negedge clk); flash_wr_req = 1'b1; lv_lockout = 1'b1; #1;
    eq("R9 lockout blocks", flash_wr_go, 0);
    lv_lockout = 1'b0; #1;
    eq("R9 write allowed", flash_wr_go, 1);
    pulse(WARM);
    eq("R9 blocked in reset", flash_wr_go, 0);
    flash_wr_req = 1'b0;
    rst_pin_n = 1'b1;
    repeat (REC + 2) @(negedge clk);
  endtask

  task automatic t_supply_drop;
    int b_pm, b, n;
    @(negedge clk); supply_ok = 1'b0; #1;
    eq("R1 drop ready", access_ready, 0);
    @(negedge clk); supply_ok = 1'b1;
    b = n_misc;
    pulse(WARM + 4);
    repeat (4) @(negedge clk);
    eq("R2 warm pulse after drop ignored", n_misc - b, 0);
    b_pm = n_pm;
    pulse(COLD);
    edges_to_ready(n);
    eq("R2 cold after drop pm strobe", n_pm - b_pm, 1);
    eq("R4 recovery after drop", n, REC);
    eq("R11 class after drop", rst_cold, 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_cold_short();
    t_cold_full();
    t_glitch();
    t_warm();
    t_pdown();
    t_lockout();
    t_supply_drop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule